// File: doc/BRIEF.md
# Self-Timed Byte Nonvolatile Memory Access Controller

This block is the processor-side controller for a small, byte-addressed nonvolatile data store. It has its own address space of 4096 bytes, kept in the block as a behavioural register array. The processor reaches it through a few simple strobes. A read strobe copies one byte to the read-data port and holds the processor for four clock cycles. An accepted write strobe holds the processor for two clock cycles. After that, the programming operation runs on its own in the background.

Programming time is not counted in processor clocks. It comes from pulses of a slow, calibrated oscillator: a number of pulses make one millisecond, and each phase of the operation lasts a number of milliseconds. Three operations exist. The first is an atomic erase followed by a write. The second is an erase alone. The third is a write alone, which can only clear bits. A busy flag and a one-cycle ready pulse let software tell when the next byte may be written.

Accidental writes are guarded against. A write strobe only starts an operation if a separate arm pulse came shortly before it. Any write strobe uses up the arm.

Top module: `nvm_byte_ctrl`

## Requirements
- R1: `rdata_o` takes the byte stored at `addr_i` in the cycle after an accepted read strobe. It holds its value in every cycle that has no read strobe. It is 0 after reset.
- R2: An accepted read strobe raises `stall_o` for exactly 4 cycles, starting the cycle after the strobe. Read and write strobes that arrive while `stall_o` is high are ignored.
- R3: An accepted write strobe raises `stall_o` for exactly 2 cycles and `busy_o` from the next cycle on, both starting the cycle after the strobe.
- R4: A pulse on `arm_i` opens a window of 4 cycles. A write strobe in any of the 4 cycles after the arm pulse can be accepted. A write strobe in the same cycle as the arm pulse, or later than the window, is ignored. Every write strobe closes the window, whether or not it is accepted.
- R5: Mode 2'b00 (erase then write) stores `wdata_i`. It lasts (ERASE_MS+WRITE_MS)*TICKS_PER_MS oscillator ticks.
- R6: Mode 2'b01 (erase only) stores 8'hFF. It lasts ERASE_MS*TICKS_PER_MS ticks.
- R7: Mode 2'b10 (write only) stores the old byte AND `wdata_i`. It lasts WRITE_MS*TICKS_PER_MS ticks.
- R8: Programming time advances only on `tick_i` pulses. Clock cycles without a tick do not shorten the operation.
- R9: `ready_o` is high for exactly one cycle when an operation completes. `busy_o` falls in that same cycle.
- R10: While `busy_o` is high, write strobes are ignored even when armed. A read of the target address returns the byte it held before the operation.
- R11: A write strobe carrying mode 2'b11 is ignored and starts nothing.
- R12: When a read strobe and a write strobe arrive in the same cycle, the read is served and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | One-cycle pulse from the calibrated oscillator |
| arm_i | input | 1 | Arm pulse that opens the write window |
| wr_stb_i | input | 1 | Write strobe |
| rd_stb_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| mode_i | input | 2 | Operation select (00 erase+write, 01 erase, 10 write, 11 none) |
| rdata_o | output | DATA_W | Read data |
| stall_o | output | 1 | Processor hold request |
| busy_o | output | 1 | Programming in progress |
| ready_o | output | 1 | One-cycle completion pulse |

## Verification
Each of the three operating modes is applied to bytes whose previous contents differ. This separates a true erase-then-write from a write alone, which only clears bits, and both from a plain erase that gives all ones. For every mode the bench counts the oscillator ticks that pass while the block is busy, so a mode that runs with the timing of another mode is detected. The arm pulse is placed at gaps of zero, one, four and five cycles before the write strobe, which tests both edges of the window. Strobes during busy, during a stall, in the same cycle as each other and with the reserved mode show whether stray requests can change the stored data or the timing.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

   typedef enum logic [1:0] {
      OP_ERASE_WRITE = 2'b00,
      OP_ERASE       = 2'b01,
      OP_WRITE       = 2'b10,
      OP_NONE        = 2'b11
   } nvm_op_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'b00,
      PH_ERASE = 2'b01,
      PH_PROG  = 2'b10
   } nvm_phase_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/nvm_arm_guard.sv
module nvm_arm_guard #(
   parameter int unsigned ARM_WIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic wr_stb_i,
   output logic armed_o
);
   localparam int unsigned CNT_W = $clog2(ARM_WIN + 1);

   if (ARM_WIN < 1) begin : g_bad_win
      $error("nvm_arm_guard: ARM_WIN must be at least 1");
   end

   logic [CNT_W-1:0] win_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (wr_stb_i) begin
         win_q <= '0;
      end else if (arm_i) begin
         win_q <= CNT_W'(ARM_WIN);
      end else if (win_q != '0) begin
         win_q <= win_q - 1'b1;
      end
   end

   assign armed_o = (win_q != '0);

endmodule

// File: rtl/nvm_stall_gen.sv
module nvm_stall_gen #(
   parameter int unsigned RD_HOLD = 4,
   parameter int unsigned WR_HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_go_i,
   input  logic wr_go_i,
   output logic stall_o
);
   localparam int unsigned HOLD_MAX = nvm_pkg::max2(RD_HOLD, WR_HOLD);
   localparam int unsigned CNT_W    = $clog2(HOLD_MAX + 1);

   if (RD_HOLD < 1 || WR_HOLD < 1) begin : g_bad_hold
      $error("nvm_stall_gen: hold counts must be at least 1");
   end

   logic [CNT_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (rd_go_i) begin
         hold_q <= CNT_W'(RD_HOLD);
      end else if (wr_go_i) begin
         hold_q <= CNT_W'(WR_HOLD);
      end else if (hold_q != '0) begin
         hold_q <= hold_q - 1'b1;
      end
   end

   assign stall_o = (hold_q != '0);

endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer
   import nvm_pkg::*;
#(
   parameter int unsigned TICKS_PER_MS = 128,
   parameter int unsigned ERASE_MS     = 8,
   parameter int unsigned WRITE_MS     = 4
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start_i,
   input  nvm_op_e op_i,
   input  logic    tick_i,
   output logic    busy_o,
   output logic    done_o
);
   localparam int unsigned MS_MAX = max2(ERASE_MS, WRITE_MS);
   localparam int unsigned MS_W   = $clog2(MS_MAX + 1);

   if (TICKS_PER_MS < 1 || ERASE_MS < 1 || WRITE_MS < 1) begin : g_bad_time
      $error("nvm_prog_timer: timing parameters must be at least 1");
   end

   nvm_phase_e       phase_q;
   nvm_op_e          op_q;
   logic [MS_W-1:0]  ms_q;
   logic [MS_W-1:0]  ms_last;
   logic             done_q;
   logic             ms_pulse;

   assign busy_o = (phase_q != PH_IDLE);
   assign done_o = done_q;

   if (TICKS_PER_MS == 1) begin : g_no_prescale
      assign ms_pulse = busy_o && tick_i;
   end else begin : g_prescale
      localparam int unsigned TICK_W = $clog2(TICKS_PER_MS);
      logic [TICK_W-1:0] tcnt_q;
      logic              tcnt_wrap;

      assign tcnt_wrap = (tcnt_q == TICK_W'(TICKS_PER_MS - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tcnt_q <= '0;
         end else if (start_i) begin
            tcnt_q <= '0;
         end else if (busy_o && tick_i) begin
            tcnt_q <= tcnt_wrap ? '0 : tcnt_q + 1'b1;
         end
      end

      assign ms_pulse = busy_o && tick_i && tcnt_wrap;
   end

   always_comb begin
      if (phase_q == PH_ERASE) begin
         ms_last = MS_W'(ERASE_MS - 1);
      end else begin
         ms_last = MS_W'(WRITE_MS - 1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         op_q    <= OP_NONE;
         ms_q    <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start_i) begin
            op_q    <= op_i;
            ms_q    <= '0;
            phase_q <= (op_i == OP_WRITE) ? PH_PROG : PH_ERASE;
         end else if (ms_pulse) begin
            if (ms_q == ms_last) begin
               ms_q <= '0;
               if (phase_q == PH_ERASE && op_q == OP_ERASE_WRITE) begin
                  phase_q <= PH_PROG;
               end else begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end
            end else begin
               ms_q <= ms_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/nvm_store.sv
module nvm_store
   import nvm_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned DATA_W      = 8,
   parameter bit          ERASED_ONES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              commit_i,
   input  logic [ADDR_W-1:0] cm_addr_i,
   input  logic [DATA_W-1:0] cm_data_i,
   input  nvm_op_e           cm_op_i
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];
   logic [DATA_W-1:0] old_byte;
   logic [DATA_W-1:0] erased_byte;
   logic [DATA_W-1:0] prog_byte;
   logic [DATA_W-1:0] next_byte;

   assign old_byte = cells[cm_addr_i];

   if (ERASED_ONES) begin : g_erase_high
      assign erased_byte = '1;
      assign prog_byte   = old_byte & cm_data_i;
   end else begin : g_erase_low
      assign erased_byte = '0;
      assign prog_byte   = old_byte | cm_data_i;
   end

   always_comb begin
      unique case (cm_op_i)
         OP_ERASE_WRITE: next_byte = cm_data_i;
         OP_ERASE:       next_byte = erased_byte;
         OP_WRITE:       next_byte = prog_byte;
         default:        next_byte = old_byte;
      endcase
   end

   always_ff @(posedge clk) begin
      if (commit_i) begin
         cells[cm_addr_i] <= next_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
      end else if (rd_en_i) begin
         rdata_o <= cells[rd_addr_i];
      end
   end

endmodule

// File: rtl/nvm_byte_ctrl.sv
module nvm_byte_ctrl
   import nvm_pkg::*;
#(
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned ARM_WIN      = 4,
   parameter int unsigned RD_HOLD      = 4,
   parameter int unsigned WR_HOLD      = 2,
   parameter int unsigned TICKS_PER_MS = 128,
   parameter int unsigned ERASE_MS     = 8,
   parameter int unsigned WRITE_MS     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              arm_i,
   input  logic              wr_stb_i,
   input  logic              rd_stb_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [1:0]        mode_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              stall_o,
   output logic              busy_o,
   output logic              ready_o
);
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("nvm_byte_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("nvm_byte_ctrl: DATA_W must be at least 1");
   end

   nvm_op_e           mode_op;
   logic              armed;
   logic              rd_go;
   logic              wr_go;
   logic              done;
   nvm_op_e           lat_op_q;
   logic [ADDR_W-1:0] lat_addr_q;
   logic [DATA_W-1:0] lat_data_q;

   assign mode_op = nvm_op_e'(mode_i);
   assign rd_go   = rd_stb_i && !stall_o;
   assign wr_go   = wr_stb_i && !rd_stb_i && armed && !busy_o && !stall_o
                    && (mode_op != OP_NONE);
   assign ready_o = done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_op_q   <= OP_NONE;
         lat_addr_q <= '0;
         lat_data_q <= '0;
      end else if (wr_go) begin
         lat_op_q   <= mode_op;
         lat_addr_q <= addr_i;
         lat_data_q <= wdata_i;
      end
   end

   nvm_arm_guard #(
      .ARM_WIN (ARM_WIN)
   ) u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (arm_i),
      .wr_stb_i (wr_stb_i),
      .armed_o  (armed)
   );

   nvm_stall_gen #(
      .RD_HOLD (RD_HOLD),
      .WR_HOLD (WR_HOLD)
   ) u_stall (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_go_i (rd_go),
      .wr_go_i (wr_go),
      .stall_o (stall_o)
   );

   nvm_prog_timer #(
      .TICKS_PER_MS (TICKS_PER_MS),
      .ERASE_MS     (ERASE_MS),
      .WRITE_MS     (WRITE_MS)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (wr_go),
      .op_i    (mode_op),
      .tick_i  (tick_i),
      .busy_o  (busy_o),
      .done_o  (done)
   );

   nvm_store #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .ERASED_ONES (1'b1)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en_i   (rd_go),
      .rd_addr_i (addr_i),
      .rdata_o   (rdata_o),
      .commit_i  (done),
      .cm_addr_i (lat_addr_q),
      .cm_data_i (lat_data_q),
      .cm_op_i   (lat_op_q)
   );

endmodule

// File: rtl/nvm_byte_ctrl_chk.sv
module nvm_byte_ctrl_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              wr_stb_i,
   input logic              rd_stb_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              stall_o,
   input logic              busy_o,
   input logic              ready_o
);
   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> !ready_o); // R9
   AST_READY_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (!busy_o && $past(busy_o))); // R9
   AST_BUSY_FALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> ready_o); // R9
   AST_BUSY_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(wr_stb_i)); // R4
   AST_READ_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb_i && !stall_o) |=> stall_o); // R2
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb_i |=> $stable(rdata_o)); // R1
   AST_STALL_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_o) |=> stall_o); // R3
   AST_BUSY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !tick_i) |=> busy_o); // R8
endmodule

bind nvm_byte_ctrl nvm_byte_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_i   (tick_i),
   .wr_stb_i (wr_stb_i),
   .rd_stb_i (rd_stb_i),
   .rdata_o  (rdata_o),
   .stall_o  (stall_o),
   .busy_o   (busy_o),
   .ready_o  (ready_o)
);

// File: tb/tb_nvm_byte_ctrl.sv
module tb_nvm_byte_ctrl;
   localparam int TPM   = 4;
   localparam int EMS   = 2;
   localparam int WMS   = 1;
   localparam int T_EW  = (EMS + WMS) * TPM;
   localparam int T_E   = EMS * TPM;
   localparam int T_W   = WMS * TPM;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        tick_en = 1'b1;
   logic        arm = 1'b0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [11:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [1:0]  mode = '0;
   logic [7:0]  rdata;
   logic        stall;
   logic        busy;
   logic        ready;

   int n_chk = 0;
   int n_fail = 0;
   int tdiv = 0;
   int busy_ticks = 0;
   int ready_cnt = 0;
   int cyc = 0;

   nvm_byte_ctrl #(
      .TICKS_PER_MS (TPM),
      .ERASE_MS     (EMS),
      .WRITE_MS     (WMS)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .arm_i    (arm),
      .wr_stb_i (wr),
      .rd_stb_i (rd),
      .addr_i   (addr),
      .wdata_i  (wdata),
      .mode_i   (mode),
      .rdata_o  (rdata),
      .stall_o  (stall),
      .busy_o   (busy),
      .ready_o  (ready)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      if (tdiv == 2) begin
         tdiv <= 0;
         tick <= tick_en;
      end else begin
         tdiv <= tdiv + 1;
         tick <= 1'b0;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (busy && tick) busy_ticks <= busy_ticks + 1;
      if (ready) ready_cnt <= ready_cnt + 1;
      if (cyc > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Drives arm, then a write strobe gap cycles later; returns at the
   // falling edge just after the strobe edge.
   task automatic issue_write(input logic [11:0] a, input logic [7:0] d,
                              input logic [1:0] m, input int gap);
      @(negedge clk);
      arm = 1'b1;
      if (gap > 0) begin
         @(negedge clk);
         arm = 1'b0;
         repeat (gap - 1) @(negedge clk);
      end
      wr = 1'b1; addr = a; wdata = d; mode = m;
      @(negedge clk);
      arm = 1'b0; wr = 1'b0;
   endtask

   task automatic wait_ready(input int s0, input int r0, input int exp_ticks,
                             input string tag);
      for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
      chk({tag, " ready with busy low"}, int'(ready), 1);
      chk({tag, " tick count"}, busy_ticks - s0, exp_ticks);
      @(negedge clk);
      chk("R9 ready single cycle", int'(ready), 0);
      chk("R9 one ready pulse", ready_cnt - r0, 1);
   endtask

   task automatic do_write(input logic [11:0] a, input logic [7:0] d,
                           input logic [1:0] m, input int gap,
                           input bit accept, input int exp_ticks,
                           input string tag);
      int s0;
      int r0;
      s0 = busy_ticks;
      r0 = ready_cnt;
      issue_write(a, d, m, gap);
      if (accept) begin
         chk({tag, " R3 busy after strobe"}, int'(busy), 1);
         chk({tag, " R3 stall cycle 1"}, int'(stall), 1);
         @(negedge clk);
         chk({tag, " R3 stall cycle 2"}, int'(stall), 1);
         @(negedge clk);
         chk({tag, " R3 stall released"}, int'(stall), 0);
         wait_ready(s0, r0, exp_ticks, tag);
      end else begin
         chk({tag, " ignored: no stall"}, int'(stall), 0);
         chk({tag, " ignored: no busy"}, int'(busy), 0);
      end
   endtask

   task automatic read_byte(input logic [11:0] a, input logic [7:0] exp,
                            input string tag);
      @(negedge clk);
      rd = 1'b1; addr = a;
      @(negedge clk);
      rd = 1'b0;
      chk({tag, " R1 data"}, int'(rdata), int'(exp));
      for (int i = 0; i < 4; i++) begin
         chk({tag, " R2 stall held"}, int'(stall), 1);
         @(negedge clk);
      end
      chk({tag, " R2 stall released"}, int'(stall), 0);
   endtask

   task automatic t_reset;
      #1;
      chk("R1 reset rdata", int'(rdata), 0);
      chk("R9 reset ready", int'(ready), 0);
      chk("R3 reset busy", int'(busy), 0);
      chk("R2 reset stall", int'(stall), 0);
   endtask

   task automatic t_erase_write;
      do_write(12'h005, 8'h5A, 2'b00, 2, 1'b1, T_EW, "R5 erase+write");
      read_byte(12'h005, 8'h5A, "R5 readback");
   endtask

   task automatic t_arm_window;
      do_write(12'h006, 8'h11, 2'b00, 0, 1'b0, 0, "R4 same-cycle arm");
      do_write(12'h006, 8'h11, 2'b00, 5, 1'b0, 0, "R4 gap 5");
      do_write(12'h006, 8'h3C, 2'b00, 4, 1'b1, T_EW, "R4 gap 4");
      do_write(12'hFFF, 8'h81, 2'b00, 1, 1'b1, T_EW, "R4 gap 1 top address");
      read_byte(12'h006, 8'h3C, "R4 readback low");
      read_byte(12'hFFF, 8'h81, "R4 readback top");
   endtask

   task automatic t_erase_only;
      do_write(12'h005, 8'h00, 2'b01, 1, 1'b1, T_E, "R6 erase only");
      read_byte(12'h005, 8'hFF, "R6 readback");
   endtask

   task automatic t_write_only;
      do_write(12'h005, 8'hF0, 2'b00, 1, 1'b1, T_EW, "R7 preload");
      do_write(12'h005, 8'h3C, 2'b10, 1, 1'b1, T_W, "R7 write only");
      read_byte(12'h005, 8'h30, "R7 AND merge");
   endtask

   task automatic t_reserved_and_clear;
      @(negedge clk);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0; wr = 1'b1; mode = 2'b11; addr = 12'h006; wdata = 8'h00;
      @(negedge clk);
      wr = 1'b0;
      chk("R11 reserved mode no busy", int'(busy), 0);
      chk("R11 reserved mode no stall", int'(stall), 0);
      wr = 1'b1; mode = 2'b00;
      @(negedge clk);
      wr = 1'b0;
      chk("R4 arm consumed by prior strobe", int'(busy), 0);
      read_byte(12'h006, 8'h3C, "R11 data untouched");
   endtask

   task automatic t_stall_ignore;
      @(negedge clk);
      rd = 1'b1; addr = 12'h005;
      @(negedge clk);
      addr = 12'h006;
      @(negedge clk);
      rd = 1'b0;
      chk("R2 read during stall ignored", int'(rdata), 8'h30);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_busy;
      int s0;
      int r0;
      int t_mid;
      s0 = busy_ticks;
      r0 = ready_cnt;
      issue_write(12'h006, 8'h11, 2'b00, 1);
      chk("R10 op started", int'(busy), 1);
      repeat (2) @(negedge clk);
      read_byte(12'h006, 8'h3C, "R10 old byte while busy");
      issue_write(12'hFFF, 8'h22, 2'b00, 1);
      chk("R10 armed write while busy no stall", int'(stall), 0);
      tick_en = 1'b0;
      repeat (2) @(negedge clk);
      t_mid = busy_ticks;
      repeat (60) @(negedge clk);
      chk("R8 busy holds without ticks", int'(busy), 1);
      chk("R8 no tick progress", busy_ticks - t_mid, 0);
      tick_en = 1'b1;
      wait_ready(s0, r0, T_EW, "R8 paused op");
      read_byte(12'h006, 8'h11, "R10 new byte after op");
      read_byte(12'hFFF, 8'h81, "R10 busy write dropped");
   endtask

   task automatic t_collision;
      @(negedge clk);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0; wr = 1'b1; rd = 1'b1; mode = 2'b00;
      addr = 12'hFFF; wdata = 8'h00;
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
      chk("R12 write dropped", int'(busy), 0);
      chk("R12 read served", int'(rdata), 8'h81);
      chk("R12 read stall", int'(stall), 1);
      repeat (5) @(negedge clk);
      read_byte(12'hFFF, 8'h81, "R12 data untouched");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_erase_write();
      t_arm_window();
      t_erase_only();
      t_write_only();
      t_stall_ignore();
      t_reserved_and_clear();
      t_busy();
      t_collision();
      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule